// File: doc/BRIEF.md
# Mask-to-vector element expander

The block turns a predicate mask into a vector value. Each mask bit chooses whether one destination element is filled entirely with ones or entirely with zeros. The block serves a SIMD datapath up to 512 bits wide. A small opcode byte and a width bit together pick one of four element sizes: 8, 16, 32 or 64 bits. A two-bit length selector picks how many bits of the destination are active: 128, 256 or 512. The element count follows from these two values, and every destination bit above the active length comes out as zero.

The decode also checks legality. A four-bit reserved operand field must be all ones, the opcode byte must be one of the two known values, and the length selector must not use its spare code. If any of these checks fails, the block raises an undefined-opcode fault and returns zero data. The result and the fault flag travel together through one output register with a valid/ready handshake. A new operation is taken only when that register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the held result must not change and `in_ready` stays low. This back-pressure reaches the input side in the same cycle.

Top module: `m2v_expander`

## Requirements
- R1: The element size comes from the opcode byte and W bit: 0x28 with W=0 gives 8 bits, 0x28 with W=1 gives 16 bits, 0x38 with W=0 gives 32 bits, and 0x38 with W=1 gives 64 bits.
- R2: Element j of the result is all ones when mask bit j is 1, and all zeros when mask bit j is 0.
- R3: The number of active elements is the active length divided by the element size. Mask bits at or above that count have no effect on the result.
- R4: Every result bit from the active length up to bit 511 is zero.
- R5: Length code 2'b00 selects 128 bits, 2'b01 selects 256 bits and 2'b10 selects 512 bits.
- R6: A reserved field other than 4'b1111 raises `out_fault`, and the result data is zero.
- R7: An opcode byte other than 0x28 or 0x38, or length code 2'b11, raises `out_fault`, and the result data is zero.
- R8: `in_ready` is high exactly when the output register is empty or being drained. An accepted operation appears on the outputs with `out_valid` one cycle later.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_fault` hold steady.
- R10: If the held result is drained in the same cycle that a new operation is accepted, the new result replaces it with no idle cycle. If the result is drained with no new operation, `out_valid` falls.
- R11: An active-low synchronous reset clears `out_valid`, `out_fault` and `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_opcode | input | 8 | Opcode byte (0x28 or 0x38) |
| in_wbit | input | 1 | Width bit that picks between the two sizes of an opcode |
| in_vlen | input | 2 | Length code |
| in_rsvd | input | 4 | Reserved operand field, must be 4'b1111 |
| in_mask | input | 64 | Predicate mask, bit j controls element j |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 512 | Expanded vector |
| out_fault | output | 1 | Undefined-opcode fault |

## Verification
The two functions that can fall in the same cycle are draining the held result and accepting a new operation. The bench first stalls the output with `out_ready` low while a second operation waits at the input. During the stall it checks that `in_ready` stays low and the held value does not change. It then raises `out_ready` while the second operation is still presented. The result is judged correct only if the second result appears on the next cycle with `out_valid` still high, and `out_valid` falls one cycle after the input goes quiet.

// File: rtl/m2v_pkg.sv
package m2v_pkg;
  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_t;

  localparam logic [1:0] LEN_SPARE = 2'b11;
  localparam logic [7:0] OPC_NARROW = 8'h28;
  localparam logic [7:0] OPC_WIDE   = 8'h38;
endpackage

// File: rtl/m2v_decode.sv
module m2v_decode
  import m2v_pkg::*;
#(
  parameter int OPC_W  = 8,
  parameter int RSVD_W = 4
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic              wbit,
  input  logic [1:0]        vlen,
  input  logic [RSVD_W-1:0] rsvd,
  output esz_t              esz,
  output logic              fault
);
  logic opc_bad;

  always_comb begin
    opc_bad = 1'b0;
    esz     = ESZ_8;
    case (opcode)
      OPC_NARROW: esz = wbit ? ESZ_16 : ESZ_8;
      OPC_WIDE:   esz = wbit ? ESZ_64 : ESZ_32;
      default:    opc_bad = 1'b1;
    endcase
  end

  assign fault = opc_bad || (rsvd != '1) || (vlen == LEN_SPARE);
endmodule

// File: rtl/m2v_expand.sv
module m2v_expand
  import m2v_pkg::*;
#(
  parameter int VEC_W  = 512,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W/LANE_W-1:0] mask,
  input  esz_t                    esz,
  input  logic [1:0]              vlen,
  output logic [VEC_W-1:0]        vec
);
  localparam int LANES  = VEC_W / LANE_W;
  localparam int LIDX_W = $clog2(LANES);
  localparam int BASE   = LANES / 4;

  logic [LIDX_W:0] act_lanes;
  assign act_lanes = (LIDX_W+1)'(BASE) << vlen;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam logic [LIDX_W:0] LANE_ID = (LIDX_W+1)'(b);
    logic [LIDX_W-1:0] elem;
    logic              on;
    assign elem = LANE_ID[LIDX_W-1:0] >> esz;
    assign on   = (LANE_ID < act_lanes) && mask[elem];
    assign vec[b*LANE_W +: LANE_W] = {LANE_W{on}};
  end
endmodule

// File: rtl/m2v_outreg.sv
module m2v_outreg #(
  parameter int W = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_fault,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_fault
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_fault <= in_fault;
      out_data  <= in_fault ? '0 : in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/m2v_expander.sv
module m2v_expander
  import m2v_pkg::*;
#(
  parameter int VEC_W  = 512,
  parameter int MASK_W = VEC_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic              in_wbit,
  input  logic [1:0]        in_vlen,
  input  logic [3:0]        in_rsvd,
  input  logic [MASK_W-1:0] in_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_data,
  output logic              out_fault
);
  localparam int LANE_W = VEC_W / MASK_W;

  esz_t             esz;
  logic             dec_fault;
  logic [VEC_W-1:0] vec;

  m2v_decode #(.OPC_W(8), .RSVD_W(4)) u_dec (
    .opcode(in_opcode), .wbit(in_wbit), .vlen(in_vlen), .rsvd(in_rsvd),
    .esz(esz), .fault(dec_fault)
  );

  m2v_expand #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_exp (
    .mask(in_mask), .esz(esz), .vlen(in_vlen), .vec(vec)
  );

  m2v_outreg #(.W(VEC_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_data(vec), .in_fault(dec_fault),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_fault(out_fault)
  );
endmodule

// File: rtl/m2v_expander_chk.sv
module m2v_expander_chk #(
  parameter int VEC_W  = 512,
  parameter int MASK_W = VEC_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_opcode,
  input logic              in_wbit,
  input logic [1:0]        in_vlen,
  input logic [3:0]        in_rsvd,
  input logic [MASK_W-1:0] in_mask,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VEC_W-1:0]  out_data,
  input logic              out_fault
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r8_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_fault)));

  a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault) |-> (out_data == '0));

  a_r6_rsvd_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_rsvd != 4'hF) |=> out_fault);

  a_r7_len_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_vlen == 2'b11) |=> out_fault);

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_vlen == 2'b00) |=> (out_data[VEC_W-1:VEC_W/4] == '0));

  a_r2_full_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mask == '1 && in_rsvd == 4'hF && in_vlen == 2'b10 &&
     (in_opcode == 8'h28 || in_opcode == 8'h38)) |=> (out_data == '1 && !out_fault));

  a_r11_reset: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_fault && out_data == '0));
endmodule

bind m2v_expander m2v_expander_chk #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_chk (.*);

// File: tb/m2v_expander_tb.sv
`timescale 1ns/1ps
module m2v_expander_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [7:0]   in_opcode;
  logic         in_wbit;
  logic [1:0]   in_vlen;
  logic [3:0]   in_rsvd;
  logic [63:0]  in_mask;
  logic         out_valid;
  logic         out_ready;
  logic [511:0] out_data;
  logic         out_fault;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  m2v_expander u_dut (.*);

  task automatic check(input bit ok, input string tag,
                       input logic [512:0] act, input logic [512:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] op, input logic w,
                                input logic [1:0] vl, input logic [3:0] rs,
                                input logic [63:0] m,
                                output logic [511:0] d, output logic f);
    int ebits = 8;
    int len;
    f = 1'b0;
    if (op == 8'h28) ebits = w ? 16 : 8;
    else if (op == 8'h38) ebits = w ? 64 : 32;
    else f = 1'b1;
    if (rs != 4'hF) f = 1'b1;
    if (vl == 2'd3) f = 1'b1;
    len = 128 << vl;
    d = '0;
    if (!f)
      for (int k = 0; k < 512; k++)
        if (k < len && m[k / ebits]) d[k] = 1'b1;
  endfunction

  task automatic xfer(input logic [7:0] op, input logic w, input logic [1:0] vl,
                      input logic [3:0] rs, input logic [63:0] m, input string tag);
    logic [511:0] ed;
    logic         ef;
    model(op, w, vl, rs, m, ed, ef);
    @(negedge clk);
    in_opcode = op; in_wbit = w; in_vlen = vl; in_rsvd = rs; in_mask = m;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_data === ed && out_fault === ef, tag,
          {out_fault, out_data}, {ef, ed});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [6];
    logic [511:0] ed_a, ed_b;
    logic ef_a, ef_b;
    pats[0] = '0; pats[1] = '1; pats[2] = 64'h5555_5555_5555_5555;
    pats[3] = 64'hAAAA_AAAA_AAAA_AAAA; pats[4] = 64'h0123_4567_89AB_CDEF;
    pats[5] = 64'h8000_0000_0000_0001;

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_opcode = 8'h28; in_wbit = 1'b0; in_vlen = 2'd0; in_rsvd = 4'hF; in_mask = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(out_valid === 1'b0 && out_fault === 1'b0 && out_data === '0, "R11",
          {out_fault, out_data}, '0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R7: sizes x lengths x masks
    for (int o = 0; o < 2; o++)
      for (int w = 0; w < 2; w++)
        for (int v = 0; v < 4; v++)
          for (int p = 0; p < 6; p++)
            xfer(o ? 8'h38 : 8'h28, 1'(w), 2'(v), 4'hF, pats[p],
                 v == 3 ? "R7" : (p == 4 ? "R1" : "R2/R5"));

    // R3: mask bits above active count ignored
    xfer(8'h28, 1'b0, 2'd0, 4'hF, 64'hFFFF_FFFF_FFFF_0000, "R3");
    xfer(8'h38, 1'b1, 2'd1, 4'hF, 64'hFFFF_FFFF_FFFF_FFF0, "R3");
    xfer(8'h38, 1'b0, 2'd2, 4'hF, 64'hFFFF_FFFF_FFFF_0000, "R3");
    // R4: upper bits zero with full mask
    xfer(8'h38, 1'b1, 2'd0, 4'hF, '1, "R4");
    xfer(8'h28, 1'b1, 2'd1, 4'hF, '1, "R4");

    // R6: every reserved field value
    for (int r = 0; r < 16; r++)
      xfer(8'h28, 1'b0, 2'd2, 4'(r), '1, "R6");

    // R7: every opcode byte with both W values
    for (int op = 0; op < 256; op++)
      for (int w = 0; w < 2; w++)
        xfer(8'(op), 1'(w), 2'd2, 4'hF, 64'hF0F0_0FF0_1234_8001, "R7");

    // R8 R9 R10: stall, then accept and drain in one cycle
    model(8'h28, 1'b0, 2'd2, 4'hF, 64'h0000_0000_FFFF_0001, ed_a, ef_a);
    model(8'h38, 1'b1, 2'd2, 4'hF, 64'h0000_0000_0000_00A5, ed_b, ef_b);
    @(negedge clk);
    out_ready = 1'b0;
    in_opcode = 8'h28; in_wbit = 1'b0; in_vlen = 2'd2; in_rsvd = 4'hF;
    in_mask = 64'h0000_0000_FFFF_0001; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b1 && out_data === ed_a, "R8", {out_fault, out_data}, {ef_a, ed_a});
    in_opcode = 8'h38; in_wbit = 1'b1; in_mask = 64'h0000_0000_0000_00A5;
    check(in_ready === 1'b0, "R8", {512'd0, in_ready}, 513'd0);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check(out_valid === 1'b1 && out_data === ed_a && out_fault === ef_a && in_ready === 1'b0,
            "R9", {out_fault, out_data}, {ef_a, ed_a});
    end
    out_ready = 1'b1;
    #1;
    check(in_ready === 1'b1, "R10", {512'd0, in_ready}, 513'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_data === ed_b && out_fault === ef_b, "R10",
          {out_fault, out_data}, {ef_b, ed_b});
    @(negedge clk);
    check(out_valid === 1'b0, "R10", {512'd0, out_valid}, 513'd0);

    // R11: reset while a fault result is held
    out_ready = 1'b0;
    in_rsvd = 4'h0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_fault === 1'b1 && out_data === '0, "R6",
          {out_fault, out_data}, {1'b1, 512'd0});
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; out_ready = 1'b1;
    check(out_valid === 1'b0 && out_fault === 1'b0 && out_data === '0, "R11",
          {out_fault, out_data}, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule